// File: doc/BRIEF.md
# Three-State Phase/Frequency Error Detector

This block compares two clocked event streams: one derived from the divided oscillator under control (the "V" side) and one from the divided reference (the "R" side). It keeps a small memory of which side produced an edge first. When the V side is ahead, either because it runs faster or because it leads in phase, the single error output drives low. When the V side is behind, the single error output drives high. When the two edges coincide, the output is released to high impedance. The output is modelled here as a data bit plus an output-enable.

The same error information is also given on two separate outputs, one for each side, for loops that use a double-ended error signal. Both inputs are sampled on the system clock. With the default parameters, each input is a level, and only its active transition counts as an event. A parameter selects plain one-cycle pulse inputs instead, and another selects which transition is active.

Top module: `pfd_tristate`

## Requirements
- R1: While `rst` is high, and after its release until the first input event, `pd_oe`, `pd_dat`, `phi_v` and `phi_r` are all 0. Reset overrides any pending error.
- R2: From the idle state, an event on `fv_in` alone that is sampled at a clock edge gives `pd_oe`=1, `pd_dat`=0 and `phi_v`=1 after that edge.
- R3: From the idle state, an event on `fr_in` alone that is sampled at a clock edge gives `pd_oe`=1, `pd_dat`=1 and `phi_r`=1 after that edge.
- R4: While one side is pending, an event on the other side returns the block to idle after that edge (`pd_oe`=0, both phase outputs 0).
- R5: Events on both inputs at the same clock edge leave the block idle after that edge, whichever side was pending before.
- R6: Further events on the pending side keep the same pending state and do not change the outputs.
- R7: With default parameters, an event is only a 0-to-1 transition of the input between consecutive clock edges. A level held high produces no further events.
- R8: `phi_v` and `phi_r` are never both 1, and `pd_oe` equals `phi_v | phi_r`. When enabled, `pd_dat` equals `phi_r`.
- R9: When `pd_oe` is 0, `pd_dat` is driven 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fv_in | input | 1 | Divided oscillator event input |
| fr_in | input | 1 | Divided reference event input |
| pd_dat | output | 1 | Single error output value (0 = sink, 1 = source) |
| pd_oe | output | 1 | Enable for the single error output; 0 means high impedance |
| phi_v | output | 1 | Double-ended output: V side ahead |
| phi_r | output | 1 | Double-ended output: R side ahead |

## Verification
The bench builds the block with its default parameters: level inputs with rising-edge detection. This brings transition detection and held-level immunity (R7) within reach, in addition to the pending-state logic. Directed runs cover each ordering of the two sides, coincident events from every state, and a reset taken while an error is pending. A long pseudo-random stretch then mixes pulse widths and spacing, so that events on one side interleave, repeat and coincide with events on the other side.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    // bit 0: V side pending, bit 1: R side pending
    typedef enum logic [1:0] {
        PFD_IDLE      = 2'b00,
        PFD_VCO_AHEAD = 2'b01,
        PFD_REF_AHEAD = 2'b10
    } pfd_state_e;

    typedef struct packed {
        logic oe;
        logic dat;
        logic up_v;
        logic up_r;
    } pfd_drive_t;

    localparam int PFD_SIDES = 2;
    localparam int SIDE_V    = 0;
    localparam int SIDE_R    = 1;

    function automatic pfd_state_e pfd_next(pfd_state_e cur, logic ev_v, logic ev_r);
        logic v_n;
        logic r_n;
        v_n = (cur == PFD_VCO_AHEAD) | ev_v;
        r_n = (cur == PFD_REF_AHEAD) | ev_r;
        if (v_n && r_n) return PFD_IDLE;
        if (v_n)        return PFD_VCO_AHEAD;
        if (r_n)        return PFD_REF_AHEAD;
        return PFD_IDLE;
    endfunction

    function automatic pfd_drive_t pfd_decode(pfd_state_e s);
        pfd_drive_t d;
        d = '0;
        case (s)
            PFD_VCO_AHEAD: begin d.oe = 1'b1; d.dat = 1'b0; d.up_v = 1'b1; end
            PFD_REF_AHEAD: begin d.oe = 1'b1; d.dat = 1'b1; d.up_r = 1'b1; end
            default:       d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pfd_edge.sv
module pfd_edge #(
    parameter bit LEVEL_IN = 1'b1,
    parameter bit RISE     = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_i,
    output logic hit_o
);
    localparam logic IDLE_LVL = ~RISE;

    generate
        if (LEVEL_IN) begin : g_level
            logic prev_q;
            always_ff @(posedge clk) begin
                if (rst) prev_q <= IDLE_LVL;
                else     prev_q <= sig_i;
            end
            assign hit_o = RISE ? (sig_i & ~prev_q) : (~sig_i & prev_q);

            // R7: two consecutive sampled events need the input to leave the active level in between
            assert_no_retrigger_R7: assert property (@(posedge clk) disable iff (rst)
                hit_o |=> !hit_o);
        end else begin : g_pulse
            assign hit_o = RISE ? sig_i : ~sig_i;
        end
    endgenerate
endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ev_v,
    input  logic       ev_r,
    output pfd_state_e state_o
);
    pfd_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= PFD_IDLE;
        else     state_q <= pfd_next(state_q, ev_v, ev_r);
    end

    assign state_o = state_q;

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> state_q == PFD_IDLE);
    assert_v_first_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == PFD_IDLE && ev_v && !ev_r) |=> state_q == PFD_VCO_AHEAD);
    assert_r_first_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == PFD_IDLE && ev_r && !ev_v) |=> state_q == PFD_REF_AHEAD);
    assert_cancel_R4: assert property (@(posedge clk) disable iff (rst)
        ((state_q == PFD_VCO_AHEAD && ev_r) || (state_q == PFD_REF_AHEAD && ev_v))
        |=> state_q == PFD_IDLE);
    assert_coincide_R5: assert property (@(posedge clk) disable iff (rst)
        (ev_v && ev_r) |=> state_q == PFD_IDLE);
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q != PFD_IDLE && !ev_v && !ev_r) |=> $stable(state_q));
endmodule

// File: rtl/pfd_drive.sv
module pfd_drive
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pfd_state_e state_i,
    output pfd_drive_t drv_o
);
    assign drv_o = pfd_decode(state_i);

    assert_one_side_R8: assert property (@(posedge clk) disable iff (rst)
        !(drv_o.up_v && drv_o.up_r) && (drv_o.oe == (drv_o.up_v | drv_o.up_r)));
    assert_polarity_R8: assert property (@(posedge clk) disable iff (rst)
        drv_o.oe |-> (drv_o.dat == drv_o.up_r));
    assert_idle_low_R9: assert property (@(posedge clk) disable iff (rst)
        !drv_o.oe |-> !drv_o.dat);
endmodule

// File: rtl/pfd_tristate.sv
module pfd_tristate
    import pfd_pkg::*;
#(
    parameter bit LEVEL_IN = 1'b1,
    parameter bit RISE     = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic fv_in,
    input  logic fr_in,
    output logic pd_dat,
    output logic pd_oe,
    output logic phi_v,
    output logic phi_r
);
    logic [PFD_SIDES-1:0] raw;
    logic [PFD_SIDES-1:0] hit;
    pfd_state_e           state;
    pfd_drive_t           drv;

    assign raw[SIDE_V] = fv_in;
    assign raw[SIDE_R] = fr_in;

    generate
        for (genvar g = 0; g < PFD_SIDES; g++) begin : g_side
            pfd_edge #(.LEVEL_IN(LEVEL_IN), .RISE(RISE)) u_edge (
                .clk   (clk),
                .rst   (rst),
                .sig_i (raw[g]),
                .hit_o (hit[g])
            );
        end
    endgenerate

    pfd_core u_core (
        .clk     (clk),
        .rst     (rst),
        .ev_v    (hit[SIDE_V]),
        .ev_r    (hit[SIDE_R]),
        .state_o (state)
    );

    pfd_drive u_drive (
        .clk     (clk),
        .rst     (rst),
        .state_i (state),
        .drv_o   (drv)
    );

    assign pd_oe  = drv.oe;
    assign pd_dat = drv.dat;
    assign phi_v  = drv.up_v;
    assign phi_r  = drv.up_r;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!pd_oe && !phi_v && !phi_r));
endmodule

// File: tb/sim_pfd_tristate.sv
module sim_pfd_tristate;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fv_in = 1'b0;
    logic fr_in = 1'b0;
    logic pd_dat, pd_oe, phi_v, phi_r;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // behavioural model: +1 V ahead, -1 R ahead, 0 balanced
    int bal    = 0;
    int prev_v = 0;
    int prev_r = 0;

    always #2 clk = ~clk;

    pfd_tristate u0 (
        .clk(clk), .rst(rst), .fv_in(fv_in), .fr_in(fr_in),
        .pd_dat(pd_dat), .pd_oe(pd_oe), .phi_v(phi_v), .phi_r(phi_r)
    );

    task automatic compare(input string tag);
        logic [3:0] act, exp;
        act = {pd_oe, pd_dat, phi_v, phi_r};
        if (bal > 0)      exp = 4'b1010;
        else if (bal < 0) exp = 4'b1101;
        else              exp = 4'b0000;
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s oe/dat/phi_v/phi_r actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // check current outputs, then drive new inputs and advance the model
    task automatic step(input string tag, input logic r, input logic v, input logic f);
        int ev, er;
        @(negedge clk);
        compare(tag);
        if (!rst) begin
            // R8 and R9 hold for every output combination checked
            checks++;
            if ((phi_v && phi_r) || (pd_oe != (phi_v | phi_r)) || (!pd_oe && pd_dat)) begin
                fails++;
                $display("FAIL R8/R9 actual oe%b dat%b v%b r%b expected consistent set", pd_oe, pd_dat, phi_v, phi_r);
            end
        end
        rst = r; fv_in = v; fr_in = f;
        if (r) begin
            bal = 0; prev_v = 0; prev_r = 0;
        end else begin
            ev = (v && !prev_v) ? 1 : 0;
            er = (f && !prev_r) ? 1 : 0;
            if (ev == 1 && er == 1) bal = 0;
            else if (ev == 1)       bal = (bal < 0) ? 0 : 1;
            else if (er == 1)       bal = (bal > 0) ? 0 : -1;
            prev_v = v; prev_r = f;
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : stim
        int lfsr;
        // R1: reset, with an input toggling inside reset
        step("R1", 1, 0, 0);
        step("R1", 1, 1, 0);
        step("R1", 1, 0, 0);
        step("R1", 0, 0, 0);
        step("R1", 0, 0, 0);
        // R2 then R6
        step("R2", 0, 1, 0);
        step("R2", 0, 0, 0);
        step("R6", 0, 1, 0);
        step("R6", 0, 0, 0);
        // R4: R side cancels
        step("R4", 0, 0, 1);
        step("R4", 0, 0, 0);
        // R3 then R6 then R4
        step("R3", 0, 0, 1);
        step("R3", 0, 0, 0);
        step("R6", 0, 0, 1);
        step("R6", 0, 0, 0);
        step("R4", 0, 1, 0);
        step("R4", 0, 0, 0);
        // R5: coincident from idle, from V pending, from R pending
        step("R5", 0, 1, 1);
        step("R5", 0, 0, 0);
        step("R5", 0, 1, 0);
        step("R5", 0, 0, 0);
        step("R5", 0, 1, 1);
        step("R5", 0, 0, 0);
        step("R5", 0, 0, 1);
        step("R5", 0, 0, 0);
        step("R5", 0, 1, 1);
        step("R5", 0, 0, 0);
        // R7: fV held high gives one event only
        step("R7", 0, 1, 0);
        for (int i = 0; i < 4; i++) step("R7", 0, 1, 0);
        step("R7", 0, 1, 1);
        step("R7", 0, 1, 0);
        step("R7", 0, 1, 1);
        for (int i = 0; i < 3; i++) step("R7", 0, 1, 1);
        step("R7", 0, 0, 0);
        step("R7", 0, 0, 0);
        // R1: reset while an error is pending
        step("R1", 0, 0, 1);
        step("R1", 0, 0, 0);
        step("R1", 1, 0, 0);
        step("R1", 0, 0, 0);
        step("R1", 0, 0, 0);
        // pseudo-random mix for R2..R8
        lfsr = 32'h1ace5;
        for (int i = 0; i < 600; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4BCD35C : 0);
            step("R8", 0, lfsr[3] & lfsr[5], lfsr[9] & lfsr[12]);
        end
        step("R8", 0, 0, 0);
        step("R8", 0, 0, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule